// File: doc/BRIEF.md
# HDLC Transmit Frame Assembler

This block turns host-loaded bytes into an HDLC bit stream. The host fills a 32-byte transmit FIFO. It then issues a transmit command, and the block sends the opening flag and the frame content. It ends the frame with the frame check sequence and a closing flag. The serial side moves one bit for each cycle in which the bit-rate enable is high.

There are two framing modes. In transparent mode, every byte between the opening flag and the check sequence comes from the FIFO. In auto mode, the block first sends one or two address bytes from its address inputs and a control field that it builds itself, and only then the FIFO bytes. The FIFO is loaded one pool at a time. A command that has its last-pool qualifier low tells the block that more pools follow. When such a pool runs dry, the block pulses an interrupt so that the host can load the next pool.

The line idles at 1 outside frames. A qualifier output marks the cycles that carry frame bits.

Top module: `hdlc_tx_asm`

## Requirements
- R1: After reset the line is idle: `tx_active` is 0, `tx_bit` is 1, `wr_ok` is 1 and `pool_irq` is 0. Whenever `tx_active` is 0, `tx_bit` is 1.
- R2: No frame bit leaves before `cmd_go` is given in the idle state. The first eight active bits are the flag 0x7E, sent LSB first and without stuffing.
- R3: In transparent mode, the frame content is the FIFO bytes in write order, each sent LSB first.
- R4: In auto mode with `addr_wide`=0, the content starts with `addr_a`, followed by the control field.
- R5: In auto mode with `addr_wide`=1, the content starts with `addr_a` and then `addr_b`, followed by the control field.
- R6: The control field comes from a send counter N that is 0 after reset and rises by one after each completed auto frame. With `ctrl_wide`=0 it is one byte equal to {3'b000, 1'b0, N[2:0], 1'b0}. With `ctrl_wide`=1 it is the byte {N[6:0], 1'b0} followed by 0x00.
- R7: The payload is followed by a CRC-16-CCITT. The CRC uses the reflected polynomial 0x8408 and a seed of 0xFFFF, and covers the address, control and payload bytes. It is sent complemented, low byte first, each byte LSB first, and the closing flag 0x7E follows it.
- R8: After any five consecutive 1 bits of content (address, control, payload or CRC), a 0 is inserted. Flag and abort bits are never stuffed.
- R9: Host writes are taken only while `wr_ok` is 1. `wr_ok` is 0 while a pool is committed or while the FIFO holds 32 bytes, and writes made then are dropped. When a non-last pool is emptied during a frame, `pool_irq` pulses for one cycle and `wr_ok` returns to 1.
- R10: A `cmd_go` issued mid-frame with `cmd_last`=1 commits the final pool. The CRC follows its last byte directly, and a final pool may hold zero bytes.
- R11: If a byte is needed while no pool is committed, eight unstuffed 1 bits (an abort) end the frame with no CRC or closing flag. The FIFO is then flushed.
- R12: `tx_active` stays high without a gap from the first opening-flag bit to the last closing-flag or abort bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-rate enable; one line bit per enabled cycle |
| wr_en | input | 1 | Host FIFO write strobe |
| wr_data | input | 8 | Host FIFO write byte |
| wr_ok | output | 1 | FIFO write-enable status |
| cmd_go | input | 1 | Transmit command: starts a frame when idle, commits the next pool otherwise |
| cmd_last | input | 1 | Qualifies `cmd_go`: the committed pool is the last of the frame |
| auto_mode | input | 1 | 1 = auto mode, 0 = transparent mode (sampled at frame start) |
| addr_wide | input | 1 | 1 = 16-bit address in auto mode |
| ctrl_wide | input | 1 | 1 = 16-bit control field in auto mode |
| addr_a | input | 8 | First address byte |
| addr_b | input | 8 | Second address byte |
| pool_irq | output | 1 | One-cycle pulse: pool emptied, load more |
| tx_bit | output | 1 | Serial line bit |
| tx_active | output | 1 | High while `tx_bit` carries frame bits |

## Verification
The assertions assume a well-behaved host in three ways. It gives `cmd_go` only while `wr_ok` shows no pool pending. It keeps the mode inputs steady around a frame start. It never writes and commits a pool in the same cycle. The bench respects all three: it writes each pool as a run of consecutive cycles and gives the command afterwards, and it changes modes only between frames. The bench drives `bit_en` every fourth cycle. A reload after `pool_irq` then finishes well inside the eight bit times that the last byte takes on the line. The one exception is the underrun case, where the bench holds back the command on purpose.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'hFF;
  localparam logic [15:0] CRC_POLY   = 16'h8408;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam int          NS_W       = 7;
  localparam int          RUN_MAX    = 5;

  // one byte handed to the serializer, with its treatment
  typedef struct packed {
    logic [7:0] data;
    logic       stuff;
    logic       crc;
  } tx_item_t;

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_ADR1, S_ADR2, S_CTL1, S_CTL2,
    S_DATA, S_CRCH, S_CLOSE, S_DONE
  } tx_state_t;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign push_ok = push && (cnt_q < CW'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp_q] <= din;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc import hdlc_tx_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic        bit_in,
  output logic [15:0] crc_nxt,
  output logic [15:0] crc_q
);
  logic [15:0] shifted;

  always_comb begin
    shifted = {1'b0, crc_q[15:1]};
    if (crc_q[0] ^ bit_in) shifted = shifted ^ CRC_POLY;
    crc_nxt = crc_q;
    if (init)      crc_nxt = CRC_SEED;
    else if (step) crc_nxt = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_nxt;
  end

  // R7
  crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == CRC_SEED));
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser import hdlc_tx_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_en,
  input  logic     item_vld,
  input  tx_item_t item,
  output logic     ld,
  output logic     busy,
  output logic     crc_step,
  output logic     crc_bit,
  output logic     line_bit,
  output logic     line_vld
);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  logic             busy_q, busy_n;
  logic [7:0]       sh_q, sh_n;
  logic [2:0]       cnt_q, cnt_n;
  logic             stf_q, stf_n, cen_q, cen_n;
  logic [RUN_W-1:0] ones_q, ones_n;
  logic             bit_q, bit_n, vld_q, vld_n;

  assign busy     = busy_q;
  assign line_bit = bit_q;
  assign line_vld = vld_q;
  assign crc_bit  = sh_q[0];

  always_comb begin
    busy_n   = busy_q;
    sh_n     = sh_q;
    cnt_n    = cnt_q;
    stf_n    = stf_q;
    cen_n    = cen_q;
    ones_n   = ones_q;
    bit_n    = bit_q;
    vld_n    = vld_q;
    ld       = 1'b0;
    crc_step = 1'b0;
    if (bit_en) begin
      bit_n = 1'b1;
      vld_n = 1'b0;
      if (!busy_q) begin
        if (item_vld) begin
          ld     = 1'b1;
          busy_n = 1'b1;
          sh_n   = item.data;
          stf_n  = item.stuff;
          cen_n  = item.crc;
          cnt_n  = '0;
        end
      end else if (ones_q == RUN_W'(RUN_MAX)) begin
        bit_n  = 1'b0;
        vld_n  = 1'b1;
        ones_n = '0;
      end else begin
        bit_n    = sh_q[0];
        vld_n    = 1'b1;
        crc_step = cen_q;
        ones_n   = (stf_q && sh_q[0]) ? ones_q + 1'b1 : '0;
        if (cnt_q == 3'd7) begin
          if (item_vld) begin
            ld    = 1'b1;
            sh_n  = item.data;
            stf_n = item.stuff;
            cen_n = item.crc;
            cnt_n = '0;
          end else begin
            busy_n = 1'b0;
          end
        end else begin
          sh_n  = {1'b0, sh_q[7:1]};
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      stf_q  <= 1'b0;
      cen_q  <= 1'b0;
      ones_q <= '0;
      bit_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      stf_q  <= stf_n;
      cen_q  <= cen_n;
      ones_q <= ones_n;
      bit_q  <= bit_n;
      vld_q  <= vld_n;
    end
  end

  // R8
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && busy_q && ones_q == RUN_W'(RUN_MAX)) |=> (line_vld && !line_bit));
  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RUN_W'(RUN_MAX));
endmodule

// File: rtl/hdlc_tx_asm.sv
module hdlc_tx_asm import hdlc_tx_pkg::*; #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       wr_ok,
  input  logic       cmd_go,
  input  logic       cmd_last,
  input  logic       auto_mode,
  input  logic       addr_wide,
  input  logic       ctrl_wide,
  input  logic [7:0] addr_a,
  input  logic [7:0] addr_b,
  output logic       pool_irq,
  output logic       tx_bit,
  output logic       tx_active
);
  localparam int CW = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  tx_state_t       st_q, st_n;
  logic            pool_q, pool_n, last_q, last_n;
  logic            auto_q, auto_n, a16_q, a16_n, c16_q, c16_n;
  logic [NS_W-1:0] ns_q, ns_n;
  logic            irq_q, irq_n;

  logic            fifo_push, fifo_pop, fifo_clr;
  logic [7:0]      fifo_dout;
  logic [CW-1:0]   fifo_cnt;
  logic            crc_init, crc_step, crc_bit;
  logic [15:0]     crc_nxt, crc_q;
  logic            itm_vld, ser_ld, ser_busy;
  tx_item_t        itm;
  logic            has_data;

  assign wr_ok     = !pool_q && (fifo_cnt < CW'(DEPTH));
  assign fifo_push = wr_en && wr_ok;
  assign has_data  = pool_q && (fifo_cnt != '0);
  assign pool_irq  = irq_q;

  hdlc_tx_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .clr(fifo_clr), .push(fifo_push), .din(wr_data),
    .pop(fifo_pop), .dout(fifo_dout), .count(fifo_cnt)
  );

  hdlc_tx_crc u_crc (
    .clk(clk), .rst_n(rst_i_n), .init(crc_init), .step(crc_step), .bit_in(crc_bit),
    .crc_nxt(crc_nxt), .crc_q(crc_q)
  );

  hdlc_tx_ser u_ser (
    .clk(clk), .rst_n(rst_i_n), .bit_en(bit_en), .item_vld(itm_vld), .item(itm),
    .ld(ser_ld), .busy(ser_busy), .crc_step(crc_step), .crc_bit(crc_bit),
    .line_bit(tx_bit), .line_vld(tx_active)
  );

  // byte offered to the serializer in each state
  always_comb begin
    itm_vld = 1'b1;
    itm     = '{data: FLAG_BYTE, stuff: 1'b0, crc: 1'b0};
    unique case (st_q)
      S_OPEN, S_CLOSE: itm = '{data: FLAG_BYTE, stuff: 1'b0, crc: 1'b0};
      S_ADR1: itm = '{data: addr_a, stuff: 1'b1, crc: 1'b1};
      S_ADR2: itm = '{data: addr_b, stuff: 1'b1, crc: 1'b1};
      S_CTL1: itm = c16_q ? '{data: {ns_q, 1'b0}, stuff: 1'b1, crc: 1'b1}
                          : '{data: {4'b0000, ns_q[2:0], 1'b0}, stuff: 1'b1, crc: 1'b1};
      S_CTL2: itm = '{data: 8'h00, stuff: 1'b1, crc: 1'b1};
      S_DATA: begin
        if (has_data)           itm = '{data: fifo_dout, stuff: 1'b1, crc: 1'b1};
        else if (pool_q && last_q) itm = '{data: ~crc_nxt[7:0], stuff: 1'b1, crc: 1'b0};
        else                    itm = '{data: ABORT_BYTE, stuff: 1'b0, crc: 1'b0};
      end
      S_CRCH: itm = '{data: ~crc_nxt[15:8], stuff: 1'b1, crc: 1'b0};
      default: itm_vld = 1'b0;
    endcase
  end

  // frame sequencing
  always_comb begin
    st_n     = st_q;
    pool_n   = pool_q;
    last_n   = last_q;
    auto_n   = auto_q;
    a16_n    = a16_q;
    c16_n    = c16_q;
    ns_n     = ns_q;
    irq_n    = 1'b0;
    crc_init = 1'b0;
    fifo_pop = 1'b0;
    fifo_clr = 1'b0;
    if (cmd_go && !pool_q && st_q != S_DONE) begin
      pool_n = 1'b1;
      last_n = cmd_last;
      if (st_q == S_IDLE) begin
        st_n     = S_OPEN;
        auto_n   = auto_mode;
        a16_n    = addr_wide;
        c16_n    = ctrl_wide;
        crc_init = 1'b1;
      end
    end
    if (ser_ld) begin
      unique case (st_q)
        S_OPEN: st_n = auto_q ? S_ADR1 : S_DATA;
        S_ADR1: st_n = a16_q ? S_ADR2 : S_CTL1;
        S_ADR2: st_n = S_CTL1;
        S_CTL1: st_n = c16_q ? S_CTL2 : S_DATA;
        S_CTL2: st_n = S_DATA;
        S_DATA: begin
          if (has_data) begin
            fifo_pop = 1'b1;
            if (fifo_cnt == CW'(1) && !last_q) begin
              pool_n = 1'b0;
              irq_n  = 1'b1;
            end
          end else if (pool_q && last_q) begin
            st_n = S_CRCH;
          end else begin
            st_n     = S_DONE;
            pool_n   = 1'b0;
            fifo_clr = 1'b1;
          end
        end
        S_CRCH: st_n = S_CLOSE;
        S_CLOSE: begin
          st_n   = S_DONE;
          pool_n = 1'b0;
          if (auto_q) ns_n = ns_q + 1'b1;
        end
        default: ;
      endcase
    end
    if (st_q == S_DONE && !ser_busy) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= S_IDLE;
      pool_q <= 1'b0;
      last_q <= 1'b0;
      auto_q <= 1'b0;
      a16_q  <= 1'b0;
      c16_q  <= 1'b0;
      ns_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pool_q <= pool_n;
      last_q <= last_n;
      auto_q <= auto_n;
      a16_q  <= a16_n;
      c16_q  <= c16_n;
      ns_q   <= ns_n;
      irq_q  <= irq_n;
    end
  end

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tx_active |-> tx_bit);
  // R9
  irq_wr_ok_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    pool_irq |-> wr_ok);
  // R9
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && !wr_ok && !fifo_pop && !fifo_clr) |=> (fifo_cnt == $past(fifo_cnt)));
  // R12
  active_tail_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == S_CRCH || st_q == S_CLOSE) |-> tx_active);
endmodule

// File: tb/hdlc_tx_asm_tb.sv
module hdlc_tx_asm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_DIV    = 4;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_go = 1'b0, cmd_last = 1'b0;
  logic       auto_mode = 1'b0, addr_wide = 1'b0, ctrl_wide = 1'b0;
  logic [7:0] addr_a = '0, addr_b = '0;
  logic       wr_ok, pool_irq, tx_bit, tx_active;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_asm u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ok(wr_ok), .cmd_go(cmd_go), .cmd_last(cmd_last), .auto_mode(auto_mode),
    .addr_wide(addr_wide), .ctrl_wide(ctrl_wide), .addr_a(addr_a), .addr_b(addr_b),
    .pool_irq(pool_irq), .tx_bit(tx_bit), .tx_active(tx_active)
  );

  int    n_run = 0, n_fail = 0;
  int    frames_done = 0;
  string cur_req = "R2";
  logic  exp_q[$];

  // bit-rate enable, changed away from the active edge
  int div_cnt = 0;
  always @(negedge clk) begin
    div_cnt = (div_cnt == BIT_DIV - 1) ? 0 : div_cnt + 1;
    bit_en  = (div_cnt == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each active line bit with the queue
  logic upd = 1'b0;
  always @(posedge clk) upd <= bit_en;
  bit   in_frame = 0;
  int   mism = 0, pos = 0, bad_pos = -1;
  logic bad_act, bad_exp;
  always @(negedge clk) begin
    if (upd) begin
      if (tx_active) begin
        logic e;
        in_frame = 1;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 1'bx;
        if (e !== tx_bit) begin
          if (mism == 0) begin bad_pos = pos; bad_act = tx_bit; bad_exp = e; end
          mism++;
        end
        pos++;
      end else if (in_frame) begin
        in_frame = 0;
        n_run++;
        if (mism != 0 || exp_q.size() != 0) begin
          n_fail++;
          $display("FAIL %s: frame bit %0d actual %b expected %b (%0d mismatches, %0d bits unsent)",
                   cur_req, bad_pos, bad_act, bad_exp, mism, exp_q.size());
        end
        exp_q.delete();
        mism = 0; pos = 0; bad_pos = -1;
        frames_done++;
      end
    end
  end

  function automatic logic [15:0] crc_calc(input logic [7:0] bytes[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (bytes[k]) begin
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ bytes[k][i];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  // driver side: push the expected line bits of one frame
  task automatic expect_frame(input bit au, input bit a16, input bit c16,
                              input logic [7:0] a, input logic [7:0] b,
                              input logic [6:0] ns, input logic [7:0] pay[$],
                              input bit abrt);
    logic [7:0] c[$];
    logic [15:0] fcs;
    int run = 0;
    for (int i = 0; i < 8; i++) exp_q.push_back(logic'((8'h7E >> i) & 1));
    if (au) begin
      c.push_back(a);
      if (a16) c.push_back(b);
      if (c16) begin c.push_back({ns, 1'b0}); c.push_back(8'h00); end
      else c.push_back({4'b0000, ns[2:0], 1'b0});
    end
    foreach (pay[k]) c.push_back(pay[k]);
    if (!abrt) begin
      fcs = ~crc_calc(c);
      c.push_back(fcs[7:0]);
      c.push_back(fcs[15:8]);
    end
    foreach (c[k]) begin
      for (int i = 0; i < 8; i++) begin
        exp_q.push_back(c[k][i]);
        run = c[k][i] ? run + 1 : 0;
        if (run == 5) begin exp_q.push_back(1'b0); run = 0; end
      end
    end
    for (int i = 0; i < 8; i++)
      exp_q.push_back(abrt ? 1'b1 : logic'((8'h7E >> i) & 1));
  endtask

  task automatic write_pool(input logic [7:0] bytes[$]);
    foreach (bytes[k]) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = bytes[k];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic command(input bit last);
    @(negedge clk);
    cmd_go = 1'b1;
    cmd_last = last;
    @(negedge clk);
    cmd_go = 1'b0;
    cmd_last = 1'b0;
  endtask

  task automatic wait_frame(input string req);
    int start = frames_done;
    int t = 0;
    while (frames_done == start && t < 20000) begin @(negedge clk); t++; end
    if (frames_done == start) chk({req, " frame timeout"}, 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_irq(output bit seen);
    int t = 0;
    seen = 0;
    while (!pool_irq && t < 5000) begin @(negedge clk); t++; end
    seen = pool_irq;
  endtask

  task automatic set_mode(input bit au, input bit a16, input bit c16,
                          input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    auto_mode = au; addr_wide = a16; ctrl_wide = c16; addr_a = a; addr_b = b;
  endtask

  int  wd = 0;
  bit  finished = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT && !finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] p[$];
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 tx_active", tx_active, 0);
    chk("R1 tx_bit", tx_bit, 1);
    chk("R1 wr_ok", wr_ok, 1);
    chk("R1 pool_irq", pool_irq, 0);

    // R2 R3 R7 R8 transparent frame, nothing sent before the command
    set_mode(0, 0, 0, 8'h00, 8'h00);
    p = '{8'h12, 8'hFF, 8'h7E};
    write_pool(p);
    repeat (40) @(negedge clk);
    chk("R2 no bits before command", tx_active, 0);
    cur_req = "R2/R3/R7/R8 transparent";
    expect_frame(0, 0, 0, 8'h00, 8'h00, 7'd0, p, 0);
    command(1);
    wait_frame("R3");

    // R4 R6 auto, 8-bit address, N=0
    set_mode(1, 0, 0, 8'h02, 8'h00);
    p = '{8'hA5};
    cur_req = "R4/R6 auto 8-bit address";
    expect_frame(1, 0, 0, 8'h02, 8'h00, 7'd0, p, 0);
    write_pool(p);
    command(1);
    wait_frame("R4");

    // R5 R6 R8 auto, 16-bit address, N=1
    set_mode(1, 1, 0, 8'hFC, 8'h03);
    p = '{8'hFF, 8'hFF};
    cur_req = "R5/R6/R8 auto 16-bit address";
    expect_frame(1, 1, 0, 8'hFC, 8'h03, 7'd1, p, 0);
    write_pool(p);
    command(1);
    wait_frame("R5");

    // R6 R10 wide control, N=2, zero-byte final pool
    set_mode(1, 1, 1, 8'h31, 8'hF8);
    p = {};
    cur_req = "R6/R10 wide control, empty pool";
    expect_frame(1, 1, 1, 8'h31, 8'hF8, 7'd2, p, 0);
    command(1);
    wait_frame("R6");

    // R9 R10 R12 two pools, dropped writes
    set_mode(0, 0, 0, 8'h00, 8'h00);
    p = {};
    for (int i = 0; i < 40; i++) p.push_back(8'((i * 37 + 5) & 8'hFF));
    cur_req = "R9/R10/R12 two pools";
    expect_frame(0, 0, 0, 8'h00, 8'h00, 7'd0, p, 0);
    write_pool(p[0:31]);
    chk("R9 wr_ok low when full", wr_ok, 0);
    command(0);
    chk("R9 wr_ok low with pool committed", wr_ok, 0);
    begin
      logic [7:0] junk[$] = '{8'h55};
      write_pool(junk);
    end
    wait_irq(seen);
    chk("R9 pool_irq on empty pool", seen, 1);
    chk("R9 wr_ok back after irq", wr_ok, 1);
    @(negedge clk);
    chk("R9 pool_irq one cycle", pool_irq, 0);
    write_pool(p[32:39]);
    command(1);
    wait_frame("R10");

    // R11 underrun abort, with an uncommitted byte left to flush
    p = '{8'h3F, 8'h81};
    cur_req = "R11 underrun abort";
    expect_frame(0, 0, 0, 8'h00, 8'h00, 7'd0, p, 1);
    write_pool(p);
    command(0);
    wait_irq(seen);
    chk("R9 pool_irq before underrun", seen, 1);
    begin
      logic [7:0] stray[$] = '{8'hEE};
      write_pool(stray);
    end
    wait_frame("R11");
    chk("R11 wr_ok after abort", wr_ok, 1);

    // R11 FIFO flushed; R6 counter unchanged by transparent frames, N=3
    set_mode(1, 0, 0, 8'h40, 8'h00);
    p = '{8'h00};
    cur_req = "R11/R6 after abort, N=3";
    expect_frame(1, 0, 0, 8'h40, 8'h00, 7'd3, p, 0);
    write_pool(p);
    command(1);
    wait_frame("R11");

    chk("R1 idle line after frames", {tx_active, tx_bit}, 2'b01);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule